// File: doc/BRIEF.md
# Dead-Time Phase Generator

This block turns a single reference waveform into two complementary clock phases that never overlap. The first phase is high while the reference is high, and the second phase is high while the reference is low. Every time the reference changes level, both phases first drop low. They stay low for a programmable number of idle clock cycles, and only then is the phase that matches the new level driven high. The reference is normally the pulse-width output of the block ahead of it in a chain.

A three-bit control register sets how the block works. One bit enables it. A second bit swaps the reference source from the hardware pin to a third bit that firmware writes, which gives a bit-bang mode. Firmware can then step the two phases by rewriting that bit, and the hardware still inserts the dead time on every step. The dead-time length comes from a separate input. It is captured each time a gap starts.

Top module: `deadband_gen`

## Requirements
- R1: After reset both phase outputs are low and the control register reads as all zero, so the block is disabled.
- R2: A control write is stored on the clock edge where the write strobe is high. The phase logic acts on the stored value one cycle later. The bit positions are: bit 0 enables the block, bit 1 selects the bit-bang source, and bit 2 is the bit-bang reference level.
- R3: With bit-bang off, the reference is the `pwm_ref_i` pin. Once the gap has ended, `phi1_o` is high while the reference is high.
- R4: A reference change seen by the phase logic drives both phases low on that clock edge. It holds them low for D+1 cycles, where D is the `dead_cycles_i` value captured at that edge.
- R5: Once the gap has ended, `phi2_o` is high while the reference is low.
- R6: `phi1_o` and `phi2_o` are never high in the same cycle.
- R7: A further reference change during a gap reloads the count from that change. Both phases stay low until the new count runs out.
- R8: While disabled, both phases are low, reference changes have no effect on them, and the gap counter is cleared. The first enable after that runs a full gap.
- R9: A dead-time value of zero still gives one cycle with both phases low at each change.
- R10: With bit-bang on, control bit 2 is the reference, and changes on `pwm_ref_i` have no effect on the phases.
- R11: When the phase logic first sees the enable bit set, it runs a D+1 cycle gap. It then drives the phase that matches the current reference level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pwm_ref_i | input | 1 | Hardware reference, normally a PWM output |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 3 | Control write data: bit 0 enable, bit 1 bit-bang select, bit 2 bit-bang level |
| dead_cycles_i | input | DT_W (8) | Dead time D in clock cycles, captured when a gap starts |
| phi1_o | output | 1 | Phase that follows a high reference |
| phi2_o | output | 1 | Phase that follows a low reference |

## Verification
A change on `pwm_ref_i` that is driven before clock edge k blanks both phases from edge k onward. The new phase is due after edge k+D+1. A control write strobed into edge k reaches the phase logic one edge later, so its phase is due after edge k+D+2. Blanking from a write starts after edge k+1, and the old phase is still visible after edge k. Each stimulus task pushes the expected phase pair together with the exact edge count at which it is due. The monitor samples on the falling edge and compares each entry only when the bench's posedge counter matches it. An entry that is still queued after its cycle has passed counts as a failure.

// File: rtl/db_pkg.sv
package db_pkg;

  localparam int unsigned CTRL_W = 3;

  // Bit order matters to firmware: [0] enable, [1] bit-bang select, [2] bit-bang level.
  typedef struct packed {
    logic bb_level;
    logic bb_sel;
    logic enable;
  } db_ctrl_t;

  typedef enum logic [1:0] {
    ST_OFF   = 2'b00,
    ST_GAP   = 2'b01,
    ST_DRIVE = 2'b10
  } db_state_e;

endpackage

// File: rtl/db_ctrl_reg.sv
module db_ctrl_reg
  import db_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [CTRL_W-1:0] wdata_i,
  output db_ctrl_t          ctrl_o
);

  db_ctrl_t ctrl_q;
  db_ctrl_t ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (we_i) begin
      ctrl_d = db_ctrl_t'(wdata_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (we_i) begin
      ctrl_q <= ctrl_d;
    end
  end

  assign ctrl_o = ctrl_q;

  // R2: a strobed write is visible in the register on the next cycle
  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (ctrl_o == $past(wdata_i)));

  // R2: without a strobe the register keeps its value
  p_hold_no_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(ctrl_o));

endmodule

// File: rtl/db_ref_track.sv
module db_ref_track (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_ref_i,
  input  logic bb_sel_i,
  input  logic bb_level_i,
  output logic level_o,
  output logic edge_o
);

  logic ref_sel;
  logic level_q;
  logic level_d;

  always_comb begin
    ref_sel = bb_sel_i ? bb_level_i : pin_ref_i;
    level_d = ref_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= 1'b0;
    end else begin
      level_q <= level_d;
    end
  end

  assign level_o = level_q;
  assign edge_o  = ref_sel ^ level_q;

  // R4: a reported change flips the tracked level on the next cycle
  p_edge_flips_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o |=> (level_o != $past(level_o)));

  // R10: with bit-bang held and its level unchanged, the pin cannot create a change
  p_pin_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bb_sel_i && $past(bb_sel_i) && (bb_level_i == $past(bb_level_i))) |-> !edge_o);

endmodule

// File: rtl/db_phase_fsm.sv
module db_phase_fsm
  import db_pkg::*;
#(
  parameter int unsigned DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable_i,
  input  logic            edge_i,
  input  logic            level_i,
  input  logic [DT_W-1:0] dead_i,
  output logic            phi1_o,
  output logic            phi2_o
);

  localparam logic [DT_W-1:0] CNT_ONE  = DT_W'(1);
  localparam logic [DT_W-1:0] CNT_ZERO = '0;

  db_state_e       state_q, state_d;
  logic [DT_W-1:0] cnt_q, cnt_d;
  logic            phi1_q, phi1_d;
  logic            phi2_q, phi2_d;
  logic            cnt_done;

  assign cnt_done = (cnt_q == CNT_ZERO);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    phi1_d  = phi1_q;
    phi2_d  = phi2_q;
    if (!enable_i) begin
      state_d = ST_OFF;
      cnt_d   = CNT_ZERO;
      phi1_d  = 1'b0;
      phi2_d  = 1'b0;
    end else begin
      unique case (state_q)
        ST_OFF: begin
          state_d = ST_GAP;
          cnt_d   = dead_i;
          phi1_d  = 1'b0;
          phi2_d  = 1'b0;
        end
        ST_GAP: begin
          if (edge_i) begin
            cnt_d = dead_i;
          end else if (cnt_done) begin
            state_d = ST_DRIVE;
            phi1_d  = level_i;
            phi2_d  = !level_i;
          end else begin
            cnt_d = cnt_q - CNT_ONE;
          end
        end
        ST_DRIVE: begin
          if (edge_i) begin
            state_d = ST_GAP;
            cnt_d   = dead_i;
            phi1_d  = 1'b0;
            phi2_d  = 1'b0;
          end
        end
        default: begin
          state_d = ST_OFF;
          cnt_d   = CNT_ZERO;
          phi1_d  = 1'b0;
          phi2_d  = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
      cnt_q   <= '0;
      phi1_q  <= 1'b0;
      phi2_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      phi1_q  <= phi1_d;
      phi2_q  <= phi2_d;
    end
  end

  assign phi1_o = phi1_q;
  assign phi2_o = phi2_q;

  // R6: the phases never overlap
  p_no_overlap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(phi1_o && phi2_o));

  // R4: any seen reference change blanks both phases on the next cycle
  p_edge_blanks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_i && edge_i) |=> (!phi1_o && !phi2_o));

  // R8: disabling forces both phases low and clears the counter
  p_off_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |=> (!phi1_o && !phi2_o && (cnt_q == CNT_ZERO)));

  // R3: phase one only while the tracked reference is high
  p_phi1_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
    phi1_o |-> level_i);

  // R5: phase two only while the tracked reference is low
  p_phi2_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    phi2_o |-> !level_i);

  // R9: a phase rises only out of an expired gap with no fresh change
  p_rise_after_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(phi1_o) || $rose(phi2_o)) |->
      $past((state_q == ST_GAP) && cnt_done && !edge_i && enable_i));

endmodule

// File: rtl/deadband_gen.sv
module deadband_gen
  import db_pkg::*;
#(
  parameter int unsigned DT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwm_ref_i,
  input  logic              ctl_we_i,
  input  logic [CTRL_W-1:0] ctl_wdata_i,
  input  logic [DT_W-1:0]   dead_cycles_i,
  output logic              phi1_o,
  output logic              phi2_o
);

  db_ctrl_t ctrl;
  logic     ref_level;
  logic     ref_edge;

  db_ctrl_reg u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (ctl_we_i),
    .wdata_i (ctl_wdata_i),
    .ctrl_o  (ctrl)
  );

  db_ref_track u_ref (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_ref_i  (pwm_ref_i),
    .bb_sel_i   (ctrl.bb_sel),
    .bb_level_i (ctrl.bb_level),
    .level_o    (ref_level),
    .edge_o     (ref_edge)
  );

  db_phase_fsm #(
    .DT_W (DT_W)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable_i (ctrl.enable),
    .edge_i   (ref_edge),
    .level_i  (ref_level),
    .dead_i   (dead_cycles_i),
    .phi1_o   (phi1_o),
    .phi2_o   (phi2_o)
  );

endmodule

// File: tb/deadband_gen_bench.sv
module deadband_gen_bench;

  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned DT_W       = 8;
  localparam int unsigned WATCHDOG   = 20000;

  logic            clk;
  logic            rst_n;
  logic            pwm_ref_i;
  logic            ctl_we_i;
  logic [2:0]      ctl_wdata_i;
  logic [DT_W-1:0] dead_cycles_i;
  logic            phi1_o;
  logic            phi2_o;

  typedef struct {
    int unsigned cyc;
    logic        p1;
    logic        p2;
    string       tag;
  } exp_t;

  exp_t        exp_q[$];
  exp_t        mon_e;
  int unsigned cyc;
  int unsigned chk_cnt;
  int unsigned fail_cnt;
  bit          overlap_seen;
  bit          done;

  deadband_gen #(.DT_W(DT_W)) u_deadband_gen (
    .clk           (clk),
    .rst_n         (rst_n),
    .pwm_ref_i     (pwm_ref_i),
    .ctl_we_i      (ctl_we_i),
    .ctl_wdata_i   (ctl_wdata_i),
    .dead_cycles_i (dead_cycles_i),
    .phi1_o        (phi1_o),
    .phi2_o        (phi2_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  initial cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: pops each expected item when its cycle comes up
  always @(negedge clk) begin
    if (rst_n) begin
      if (phi1_o && phi2_o) overlap_seen = 1'b1;
      while (exp_q.size() > 0 && exp_q[0].cyc <= cyc) begin
        mon_e = exp_q.pop_front();
        chk_cnt++;
        if (mon_e.cyc != cyc || phi1_o !== mon_e.p1 || phi2_o !== mon_e.p2) begin
          fail_cnt++;
          $display("FAIL %s: phi1/phi2 got %b%b expected %b%b (due cycle %0d, now %0d)",
                   mon_e.tag, phi1_o, phi2_o, mon_e.p1, mon_e.p2, mon_e.cyc, cyc);
        end
      end
    end
  end

  task automatic expect_at(input int unsigned dly, input logic p1, input logic p2,
                           input string tag);
    exp_t e;
    e.cyc = cyc + dly;
    e.p1  = p1;
    e.p2  = p2;
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic step(input int unsigned n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ctl_write(input logic [2:0] v);
    ctl_we_i    = 1'b1;
    ctl_wdata_i = v;
    step(1);
    ctl_we_i    = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", chk_cnt - fail_cnt, chk_cnt);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    if (!done) begin
      chk_cnt++;
      fail_cnt++;
      $display("FAIL watchdog: run hung, got running expected finished");
      finish_run();
    end
  end

  initial begin
    int unsigned base;
    chk_cnt = 0; fail_cnt = 0; overlap_seen = 1'b0; done = 1'b0;
    rst_n = 1'b0; pwm_ref_i = 1'b0; ctl_we_i = 1'b0; ctl_wdata_i = '0;
    dead_cycles_i = '0;
    step(3);
    rst_n = 1'b1;
    // R1: outputs low after reset, block disabled
    expect_at(1, 0, 0, "R1 reset");
    pwm_ref_i = 1'b1;
    step(3);
    expect_at(1, 0, 0, "R1 disabled after reset ignores pin");
    step(2);

    // R11/R2: enable via bit 0, D=3, reference already high
    dead_cycles_i = 8'd3;
    expect_at(1, 0, 0, "R2 write not yet acted on");
    expect_at(5, 0, 0, "R11 gap last cycle");
    expect_at(6, 1, 0, "R11 phase after enable");
    ctl_write(3'b001);
    step(8);

    // R4/R5: falling reference, D=3
    expect_at(1, 0, 0, "R4 blank on change");
    expect_at(4, 0, 0, "R4 gap end");
    expect_at(5, 0, 1, "R5 phi2 follows low");
    pwm_ref_i = 1'b0;
    step(8);

    // R3: rising reference
    expect_at(4, 0, 0, "R3 gap end");
    expect_at(5, 1, 0, "R3 phi1 follows high");
    pwm_ref_i = 1'b1;
    step(8);

    // R7: retrigger during gap, D=4
    dead_cycles_i = 8'd4;
    expect_at(1, 0, 0, "R7 blank");
    expect_at(6, 0, 0, "R7 first count discarded");
    expect_at(7, 0, 0, "R7 restarted gap end");
    expect_at(8, 1, 0, "R7 phase after restart");
    pwm_ref_i = 1'b0;
    step(2);
    pwm_ref_i = 1'b1;
    step(10);

    // R9: zero dead time still blanks one cycle
    dead_cycles_i = 8'd0;
    expect_at(1, 0, 0, "R9 one-cycle gap");
    expect_at(2, 0, 1, "R9 phase after zero gap");
    pwm_ref_i = 1'b0;
    step(4);

    // R10/R2: bit-bang select (bit 1) with level bit 2 high, D=2
    dead_cycles_i = 8'd2;
    expect_at(1, 0, 1, "R2 old phase before write acts");
    expect_at(2, 0, 0, "R10 blank from bit-bang change");
    expect_at(4, 0, 0, "R10 gap end");
    expect_at(5, 1, 0, "R10 phi1 from bit-bang level");
    ctl_write(3'b111);
    step(6);
    base = cyc;
    for (int i = 0; i < 4; i++) begin
      expect_at(1, 1, 0, "R10 pin ignored in bit-bang");
      pwm_ref_i = ~pwm_ref_i;
      step(1);
    end
    step(2);
    expect_at(1, 1, 0, "R10 old phase before write acts");
    expect_at(2, 0, 0, "R10 blank from bit-bang low");
    expect_at(5, 0, 1, "R10 phi2 from bit-bang level");
    ctl_write(3'b011);
    step(7);

    // R8: disable, pin ignored, then full gap on re-enable
    expect_at(2, 0, 0, "R8 off");
    ctl_write(3'b000);
    step(2);
    for (int i = 0; i < 4; i++) begin
      expect_at(1, 0, 0, "R8 pin ignored while off");
      pwm_ref_i = ~pwm_ref_i;
      step(1);
    end
    pwm_ref_i = 1'b1;
    step(3);
    expect_at(4, 0, 0, "R8 full gap after re-enable");
    expect_at(5, 1, 0, "R8 phase after re-enable");
    ctl_write(3'b001);
    step(8);

    // R6: no overlap across the whole run
    chk_cnt++;
    if (overlap_seen) begin
      fail_cnt++;
      $display("FAIL R6: overlap got 1 expected 0");
    end
    chk_cnt++;
    if (exp_q.size() != 0) begin
      fail_cnt++;
      $display("FAIL R4: pending items got %0d expected 0", exp_q.size());
    end
    if (base == 0) $display("note: bit-bang segment not reached");
    finish_run();
  end

endmodule